// File: doc/BRIEF.md
# Masked Search Unit with Global Mask Pairs

This block pairs a small content-matched data array with a file of global mask registers. The host loads 72-bit mask registers one at a time, grouped into two banks of thirty-two. Each command names a bank and a 4-bit pair index. That index picks two neighbouring registers, which together form a 144-bit mask. The mask decides which comparand bits take part in a search. It also decides which stored bits a write may change.

A search compares the masked comparand against all array entries in parallel. The lowest-numbered matching entry is reported on registered outputs. The same entry number is written into one of sixteen result registers (two banks of eight), together with a valid flag. Later indirect reads and writes take their entry address from a result register. They are carried out only when that register's valid flag is set. Direct reads and writes by entry address are also provided, so the array can be loaded and inspected.

Top module: `gmr_search_unit`

## Requirements
- R1: After reset every mask register holds all ones, every result register is invalid, and every array entry holds zero.
- R2: A mask write names a bank (1 bit) and a register number (5 bits). Pair p is built from registers 2p and 2p+1 of the chosen bank. The even register supplies bits 71:0 of the 144-bit mask and the odd register supplies bits 143:72.
- R3: In a search, a mask bit of 1 makes that bit position compare. A mask bit of 0 makes that position match whatever the stored and comparand bits are.
- R4: When several entries match, the reported index is the lowest-numbered matching entry.
- R5: When no entry matches, `srch_hit` is 0 and `srch_idx` is 0. The named result register is written with its valid flag cleared.
- R6: A search is accepted on a clock edge. On that same edge `srch_done` is set for one cycle, `srch_hit` and `srch_idx` are loaded, and the named result register is updated.
- R7: A write (opcode 1 or 2) changes only the entry bits where the selected mask is 1. Bits where the mask is 0 keep their stored value.
- R8: An indirect write (opcode 2) targets the entry index held in the named result register. When that register is invalid, no entry changes.
- R9: An indirect read (opcode 4) sets `rd_valid` one cycle later, with `rd_data` holding the entry addressed by the named result register, only if that register is valid. `rd_valid` is 0 in every cycle that does not follow an accepted read.
- R10: Mask pairs in the two banks are independent. Result registers with the same number in the two result banks are independent.
- R11: A direct write (opcode 1) and a direct read (opcode 3) address the entry given on `cmd_addr`. A direct read always returns `rd_valid`=1 and the entry one cycle later. Opcode 0 is a search, and opcodes 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreg_we | input | 1 | Mask register write strobe |
| mreg_bank | input | 1 | Mask bank for the register write |
| mreg_num | input | 5 | Register number inside the bank |
| mreg_wdata | input | 72 | Mask value to store |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 search, 1 direct write, 2 indirect write, 3 direct read, 4 indirect read |
| cmd_mbank | input | 1 | Mask bank used by the command |
| cmd_mpair | input | 4 | Mask pair index inside that bank |
| cmd_rbank | input | 1 | Result register bank |
| cmd_rsel | input | 3 | Result register number |
| cmd_addr | input | 4 | Entry address for direct operations |
| cmd_data | input | 144 | Comparand or write data |
| srch_done | output | 1 | One-cycle pulse after a search |
| srch_hit | output | 1 | Last search found a match |
| srch_idx | output | 4 | Entry index of the last search |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 144 | Entry contents returned by a read |

## Verification
Entries are loaded so that the low half encodes the entry number modulo four and the high half encodes it divided by two. All entries are distinct under a full mask. Masks that compare only one half then produce groups of duplicates. Every entry's own pattern is searched under six mask selections across both banks: full, upper-only, lower-only, none, and a low-nibble mask. This separates the even/odd mapping, the bank choice and the lowest-index priority. A second sweep flips bits that only some masks ignore, which tells forced-match positions from compared ones. Masked and suppressed indirect writes are then checked by reading every entry back.

// File: rtl/gmr_pkg.sv
package gmr_pkg;
  typedef enum logic [2:0] {
    OP_SEARCH = 3'd0,
    OP_WR_DIR = 3'd1,
    OP_WR_IND = 3'd2,
    OP_RD_DIR = 3'd3,
    OP_RD_IND = 3'd4
  } gmr_op_e;
endpackage

// File: rtl/gmr_mask_file.sv
module gmr_mask_file #(
  parameter int WORD_W = 72,
  parameter int PAIRS  = 16,
  parameter int BANKS  = 2,
  localparam int REGS   = 2 * PAIRS,
  localparam int REG_W  = $clog2(REGS),
  localparam int PAIR_W = $clog2(PAIRS),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BANK_W-1:0]     wr_bank,
  input  logic [REG_W-1:0]      wr_reg,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [BANK_W-1:0]     rd_bank,
  input  logic [PAIR_W-1:0]     rd_pair,
  output logic [2*WORD_W-1:0]   rd_mask
);
  logic [WORD_W-1:0] regs_q [BANKS][REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < REGS; r++)
          regs_q[b][r] <= '1;
    end else if (wr_en) begin
      regs_q[wr_bank][wr_reg] <= wr_data;
    end
  end

  // Even register forms the low half, odd register the high half.
  always_comb begin
    rd_mask = {regs_q[rd_bank][{rd_pair, 1'b1}], regs_q[rd_bank][{rd_pair, 1'b0}]};
  end
endmodule

// File: rtl/gmr_match_array.sv
module gmr_match_array #(
  parameter int SRCH_W  = 144,
  parameter int ENTRIES = 16,
  localparam int EIDX_W = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRCH_W-1:0]   key,
  input  logic [SRCH_W-1:0]   cmp_mask,
  output logic [ENTRIES-1:0]  match_vec,
  output logic                any_hit,
  output logic [EIDX_W-1:0]   hit_idx,
  input  logic                wr_en,
  input  logic [EIDX_W-1:0]   wr_addr,
  input  logic [SRCH_W-1:0]   wr_data,
  input  logic [SRCH_W-1:0]   wr_mask,
  input  logic [EIDX_W-1:0]   rd_addr,
  output logic [SRCH_W-1:0]   rd_word
);
  logic [SRCH_W-1:0] ent_q [ENTRIES];

  function automatic logic masked_eq(input logic [SRCH_W-1:0] a,
                                     input logic [SRCH_W-1:0] b,
                                     input logic [SRCH_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  function automatic logic [SRCH_W-1:0] merge_bits(input logic [SRCH_W-1:0] old_v,
                                                   input logic [SRCH_W-1:0] new_v,
                                                   input logic [SRCH_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [EIDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [EIDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) r = EIDX_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = masked_eq(ent_q[g], key, cmp_mask);
  end

  assign any_hit = |match_vec;
  assign hit_idx = lowest_set(match_vec);
  assign rd_word = ent_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) ent_q[e] <= '0;
    end else if (wr_en) begin
      ent_q[wr_addr] <= merge_bits(ent_q[wr_addr], wr_data, wr_mask);
    end
  end
endmodule

// File: rtl/gmr_result_file.sv
module gmr_result_file #(
  parameter int ENTRIES  = 16,
  parameter int RES_REGS = 8,
  parameter int BANKS    = 2,
  localparam int EIDX_W = $clog2(ENTRIES),
  localparam int RSEL_W = $clog2(RES_REGS),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [BANK_W-1:0]  upd_bank,
  input  logic [RSEL_W-1:0]  upd_sel,
  input  logic               upd_valid,
  input  logic [EIDX_W-1:0]  upd_idx,
  input  logic [BANK_W-1:0]  lk_bank,
  input  logic [RSEL_W-1:0]  lk_sel,
  output logic               lk_valid,
  output logic [EIDX_W-1:0]  lk_idx
);
  logic              vld_q [BANKS][RES_REGS];
  logic [EIDX_W-1:0] idx_q [BANKS][RES_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < RES_REGS; r++) begin
          vld_q[b][r] <= 1'b0;
          idx_q[b][r] <= '0;
        end
    end else if (upd_en) begin
      vld_q[upd_bank][upd_sel] <= upd_valid;
      idx_q[upd_bank][upd_sel] <= upd_idx;
    end
  end

  assign lk_valid = vld_q[lk_bank][lk_sel];
  assign lk_idx   = idx_q[lk_bank][lk_sel];
endmodule

// File: rtl/gmr_search_unit.sv
module gmr_search_unit #(
  parameter int WORD_W   = 72,
  parameter int PAIRS    = 16,
  parameter int BANKS    = 2,
  parameter int ENTRIES  = 16,
  parameter int RES_REGS = 8,
  localparam int SRCH_W = 2 * WORD_W,
  localparam int REG_W  = $clog2(2 * PAIRS),
  localparam int PAIR_W = $clog2(PAIRS),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int EIDX_W = $clog2(ENTRIES),
  localparam int RSEL_W = $clog2(RES_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mreg_we,
  input  logic [BANK_W-1:0]  mreg_bank,
  input  logic [REG_W-1:0]   mreg_num,
  input  logic [WORD_W-1:0]  mreg_wdata,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [BANK_W-1:0]  cmd_mbank,
  input  logic [PAIR_W-1:0]  cmd_mpair,
  input  logic [BANK_W-1:0]  cmd_rbank,
  input  logic [RSEL_W-1:0]  cmd_rsel,
  input  logic [EIDX_W-1:0]  cmd_addr,
  input  logic [SRCH_W-1:0]  cmd_data,
  output logic               srch_done,
  output logic               srch_hit,
  output logic [EIDX_W-1:0]  srch_idx,
  output logic               rd_valid,
  output logic [SRCH_W-1:0]  rd_data
);
  import gmr_pkg::*;

  // Decoded command events, named for the checker.
  logic search_fire, wrd_fire, wri_fire, rdd_fire, rdi_fire;
  assign search_fire = cmd_valid && (cmd_op == OP_SEARCH);
  assign wrd_fire    = cmd_valid && (cmd_op == OP_WR_DIR);
  assign wri_fire    = cmd_valid && (cmd_op == OP_WR_IND);
  assign rdd_fire    = cmd_valid && (cmd_op == OP_RD_DIR);
  assign rdi_fire    = cmd_valid && (cmd_op == OP_RD_IND);

  logic [SRCH_W-1:0] sel_mask;
  logic [ENTRIES-1:0] match_vec;
  logic               any_hit;
  logic [EIDX_W-1:0]  hit_idx;
  logic               res_valid;
  logic [EIDX_W-1:0]  res_idx;
  logic               arr_wr_en;
  logic [EIDX_W-1:0]  arr_wr_addr;
  logic [EIDX_W-1:0]  arr_rd_addr;
  logic [SRCH_W-1:0]  arr_rd_word;
  logic               rd_grant;
  logic               wr_suppress;

  gmr_mask_file #(.WORD_W(WORD_W), .PAIRS(PAIRS), .BANKS(BANKS)) u_masks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mreg_we),
    .wr_bank (mreg_bank),
    .wr_reg  (mreg_num),
    .wr_data (mreg_wdata),
    .rd_bank (cmd_mbank),
    .rd_pair (cmd_mpair),
    .rd_mask (sel_mask)
  );

  gmr_result_file #(.ENTRIES(ENTRIES), .RES_REGS(RES_REGS), .BANKS(BANKS)) u_results (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (search_fire),
    .upd_bank  (cmd_rbank),
    .upd_sel   (cmd_rsel),
    .upd_valid (any_hit),
    .upd_idx   (hit_idx),
    .lk_bank   (cmd_rbank),
    .lk_sel    (cmd_rsel),
    .lk_valid  (res_valid),
    .lk_idx    (res_idx)
  );

  assign arr_wr_en   = wrd_fire || (wri_fire && res_valid);
  assign wr_suppress = wri_fire && !res_valid;
  assign arr_wr_addr = wrd_fire ? cmd_addr : res_idx;
  assign arr_rd_addr = rdd_fire ? cmd_addr : res_idx;
  assign rd_grant    = rdd_fire || (rdi_fire && res_valid);

  gmr_match_array #(.SRCH_W(SRCH_W), .ENTRIES(ENTRIES)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .key       (cmd_data),
    .cmp_mask  (sel_mask),
    .match_vec (match_vec),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx),
    .wr_en     (arr_wr_en),
    .wr_addr   (arr_wr_addr),
    .wr_data   (cmd_data),
    .wr_mask   (sel_mask),
    .rd_addr   (arr_rd_addr),
    .rd_word   (arr_rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_done <= 1'b0;
      srch_hit  <= 1'b0;
      srch_idx  <= '0;
    end else begin
      srch_done <= search_fire;
      if (search_fire) begin
        srch_hit <= any_hit;
        srch_idx <= any_hit ? hit_idx : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_grant;
      if (rd_grant) rd_data <= arr_rd_word;
    end
  end
endmodule

// File: rtl/gmr_search_chk.sv
module gmr_search_chk #(
  parameter int ENTRIES = 16,
  localparam int EIDX_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               search_fire,
  input logic               rdd_fire,
  input logic               rdi_fire,
  input logic [ENTRIES-1:0] match_vec,
  input logic               srch_done,
  input logic               srch_hit,
  input logic [EIDX_W-1:0]  srch_idx,
  input logic               rd_valid
);
  // R6
  a_r6_done_tracks_search: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done == $past(search_fire));

  // R9
  a_r9_read_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rdd_fire || rdi_fire));

  // R3
  a_r3_hit_matches_vector: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (srch_hit == $past(|match_vec)));

  // R4
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && srch_hit) |->
      ((($past(match_vec) >> srch_idx) & 1) == 1) &&
      (($past(match_vec) & ((ENTRIES'(1) << srch_idx) - 1)) == 0));

  // R5
  a_r5_miss_zero_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && !srch_hit) |-> (srch_idx == '0));
endmodule

bind gmr_search_unit gmr_search_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .search_fire (search_fire),
  .rdd_fire    (rdd_fire),
  .rdi_fire    (rdi_fire),
  .match_vec   (match_vec),
  .srch_done   (srch_done),
  .srch_hit    (srch_hit),
  .srch_idx    (srch_idx),
  .rd_valid    (rd_valid)
);

// File: tb/gmr_search_unit_tb.sv
module gmr_search_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         mreg_we = 0;
  logic         mreg_bank = 0;
  logic [4:0]   mreg_num = 0;
  logic [71:0]  mreg_wdata = 0;
  logic         cmd_valid = 0;
  logic [2:0]   cmd_op = 0;
  logic         cmd_mbank = 0;
  logic [3:0]   cmd_mpair = 0;
  logic         cmd_rbank = 0;
  logic [2:0]   cmd_rsel = 0;
  logic [3:0]   cmd_addr = 0;
  logic [143:0] cmd_data = 0;
  logic         srch_done, srch_hit, rd_valid;
  logic [3:0]   srch_idx;
  logic [143:0] rd_data;

  gmr_search_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .mreg_we(mreg_we), .mreg_bank(mreg_bank), .mreg_num(mreg_num), .mreg_wdata(mreg_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mbank(cmd_mbank), .cmd_mpair(cmd_mpair),
    .cmd_rbank(cmd_rbank), .cmd_rsel(cmd_rsel), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .srch_done(srch_done), .srch_hit(srch_hit), .srch_idx(srch_idx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;

  // Bench-side model state.
  logic [71:0]  m_mask [2][32];
  logic [143:0] m_ent  [16];
  logic         m_rv   [2][8];
  logic [3:0]   m_ri   [2][8];

  task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [143:0] pair_mask(input int b, input int p);
    return {m_mask[b][2*p+1], m_mask[b][2*p]};
  endfunction

  function automatic logic [143:0] ent_pat(input int e);
    logic [71:0] hi, lo;
    hi = 72'h5A_0000_0000_0000_0000 | 72'(e / 2);
    lo = 72'hC3_0000_0000_0000_0000 | 72'(e % 4);
    return {hi, lo};
  endfunction

  task automatic mask_wr(input int b, input int r, input logic [71:0] v);
    mreg_we = 1; mreg_bank = b[0]; mreg_num = 5'(r); mreg_wdata = v;
    @(posedge clk); @(negedge clk);
    mreg_we = 0;
    m_mask[b][r] = v;
  endtask

  task automatic issue(input logic [2:0] op, input int mb, input int mp, input int rb,
                       input int rs, input int addr, input logic [143:0] d);
    cmd_valid = 1; cmd_op = op; cmd_mbank = mb[0]; cmd_mpair = 4'(mp);
    cmd_rbank = rb[0]; cmd_rsel = 3'(rs); cmd_addr = 4'(addr); cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  // Search plus model update and checks of the registered results.
  task automatic do_search(input int mb, input int mp, input int rb, input int rs,
                           input logic [143:0] key, input string req);
    logic [143:0] m;
    bit hit;
    int idx;
    m = pair_mask(mb, mp);
    hit = 0; idx = 0;
    for (int e = 15; e >= 0; e--)
      if (((m_ent[e] ^ key) & m) == '0) begin hit = 1; idx = e; end
    issue(3'd0, mb, mp, rb, rs, 0, key);
    m_rv[rb][rs] = hit;
    m_ri[rb][rs] = 4'(idx);
    chk(srch_done == 1'b1, {req, " R6 done"}, 144'(srch_done), 144'(1));
    chk(srch_hit == hit, {req, " hit"}, 144'(srch_hit), 144'(hit));
    chk(srch_idx == 4'(idx), {req, " idx"}, 144'(srch_idx), 144'(idx));
  endtask

  task automatic read_ind(input int rb, input int rs, input string req);
    issue(3'd4, 0, 0, rb, rs, 0, '0);
    chk(rd_valid == m_rv[rb][rs], {req, " R9 rd_valid"}, 144'(rd_valid), 144'(m_rv[rb][rs]));
    if (m_rv[rb][rs])
      chk(rd_data == m_ent[m_ri[rb][rs]], {req, " R9 rd_data"}, rd_data, m_ent[m_ri[rb][rs]]);
  endtask

  task automatic read_dir(input int a, input string req);
    issue(3'd3, 0, 0, 0, 0, a, '0);
    chk(rd_valid == 1'b1, {req, " R11 rd_valid"}, 144'(rd_valid), 144'(1));
    chk(rd_data == m_ent[a], {req, " R11 rd_data"}, rd_data, m_ent[a]);
  endtask

  task automatic write_dir(input int mb, input int mp, input int a, input logic [143:0] d);
    logic [143:0] m;
    m = pair_mask(mb, mp);
    issue(3'd1, mb, mp, 0, 0, a, d);
    m_ent[a] = (m_ent[a] & ~m) | (d & m);
  endtask

  task automatic write_ind(input int mb, input int mp, input int rb, input int rs, input logic [143:0] d);
    logic [143:0] m;
    m = pair_mask(mb, mp);
    issue(3'd2, mb, mp, rb, rs, 0, d);
    if (m_rv[rb][rs]) m_ent[m_ri[rb][rs]] = (m_ent[m_ri[rb][rs]] & ~m) | (d & m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 32; r++) m_mask[b][r] = '1;
      for (int r = 0; r < 8; r++) begin m_rv[b][r] = 0; m_ri[b][r] = 0; end
    end
    for (int e = 0; e < 16; e++) m_ent[e] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state at the ports.
    chk(srch_done == 0, "R1 srch_done", 144'(srch_done), 0);
    chk(rd_valid == 0, "R1 rd_valid", 144'(rd_valid), 0);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++) read_ind(b, r, "R1 invalid result");
    for (int a = 0; a < 16; a++) read_dir(a, "R1 zero entry");
    do_search(0, 0, 0, 0, '0, "R1 zero search");

    // R11: load entries with direct writes under the reset all-ones mask.
    for (int a = 0; a < 16; a++) write_dir(0, 0, a, ent_pat(a));
    for (int a = 0; a < 16; a++) read_dir(a, "R11 load");

    // R2 / R10: program pairs in both banks.
    mask_wr(0, 2, 72'h0);          // bank0 pair1 even -> upper half only
    mask_wr(1, 3, 72'h0);          // bank1 pair1 odd  -> lower half only
    mask_wr(0, 4, 72'h0);          // bank0 pair2 -> nothing compared
    mask_wr(0, 5, 72'h0);
    mask_wr(1, 30, 72'hF);         // bank1 pair15 -> low nibble only
    mask_wr(1, 31, 72'h0);
    mask_wr(0, 8, 72'hFF);         // bank0 pair4 -> low byte only
    mask_wr(0, 9, 72'h0);

    // R3 / R4 / R10 sweep, then perturbed sweep for forced-match bits.
    for (int pass = 0; pass < 2; pass++)
      for (int t = 0; t < 16; t++) begin
        logic [143:0] key;
        key = ent_pat(t);
        if (pass == 1) key = key ^ {72'h0, 72'hFF00};
        do_search(0, 0, t / 8, t % 8, key, "R3 full");
        read_ind(t / 8, t % 8, "R10 result store");
        do_search(1, 0, 0, 1, key, "R10 bank1 full");
        do_search(0, 1, 0, 2, key, "R2 upper R4");
        do_search(1, 1, 1, 2, key, "R2 lower R4");
        do_search(0, 2, 0, 3, key, "R3 none R4");
        do_search(1, 15, 1, 3, key, "R3 nibble");
        read_ind(1, 3, "R10 bank1 reg3");
      end

    // R6: no pulse without a search.
    chk(srch_done == 0, "R6 idle", 144'(srch_done), 0);
    issue(3'd6, 0, 0, 0, 0, 0, '1);
    chk(srch_done == 0 && rd_valid == 0, "R11 unused opcode", 144'({srch_done, rd_valid}), 0);

    // R7 / R8: masked indirect write through a valid result register.
    do_search(0, 0, 0, 2, ent_pat(6), "R8 locate");
    write_ind(0, 4, 0, 2, '1);
    read_dir(6, "R7 masked merge");
    for (int a = 0; a < 16; a++) read_dir(a, "R7 others kept");

    // R5 / R8 / R9: miss invalidates, indirect write then suppressed.
    do_search(0, 0, 0, 2, '1, "R5 miss");
    read_ind(0, 2, "R5 invalid after miss");
    write_ind(0, 0, 0, 2, 144'h0);
    for (int a = 0; a < 16; a++) read_dir(a, "R8 suppressed");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule